// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block picks, every cycle, which hardware threads the fetch stage of a simultaneous-multithreading core reads from, and how many of the fetch slots each chosen thread receives. It offers static rotating splits (the whole width to one thread, half to each of two, or a quarter to each of four) and dynamic modes that favour the eligible thread with the smallest live occupancy counter: fewest in-flight branches, fewest outstanding cache misses, or fewest in-flight instructions. A split mode keeps a primary thread (thread 0) in front and hands the rest of the width to a second thread once the primary reports a long-latency instruction inside the fetch group.

The selection is made from the inputs sampled at a rising clock edge and appears on the outputs after that edge. A single rotating pointer is shared by all modes. It supplies the round-robin order of the static modes, the choice of the second thread in split mode, and the tie-break of the dynamic modes, so that no eligible thread is starved. The results are given as one slot per thread position, and each slot carries a thread ID and an instruction count. The thread count must be a power of two, at least 4, and the fetch width must divide by 4.

Top module: `smt_fetch_sel`

## Requirements
- R1: While rst_ni is low, every slot thread ID and slot count is 0 and the rotating pointer is 0.
- R2: The outputs change only at a rising edge and show the choice made from the inputs sampled at that edge. The outputs are the result of a single register stage.
- R3: When mode_i = 0 and at least one thread is eligible, slot 0 gets the first eligible thread met when scanning upward from the pointer (with wrap) and a count of FETCH_W.
- R4: When mode_i = 1, slots 0 and 1 get the first two eligible threads in pointer order, with FETCH_W/2 each. If only one thread is eligible, slot 1 stays at ID 0, count 0.
- R5: When mode_i = 2, slots 0 to 3 get up to four eligible threads in pointer order, with FETCH_W/4 each. Slots that are not filled stay at ID 0, count 0.
- R6: After each cycle in which any slot count is nonzero, the pointer becomes one more (mod NUM_THREADS) than the thread ID of the highest-numbered nonzero slot. Otherwise it holds its value.
- R7: When mode_i = 3 and long_lat_i is low, slot 0 holds thread 0 with a count of FETCH_W if thread 0 is eligible, and slot 1 is 0.
- R8: When mode_i = 3 and long_lat_i is high, slot 0 (thread 0) gets min(lead_run_i, FETCH_W). Slot 1 gets the first eligible thread other than 0 in pointer order, with the remaining count. If thread 0 is not eligible, slot 1 gets all FETCH_W. If no second thread is eligible, slot 1 is 0.
- R9: When mode_i = 4, 5 or 6, slot 0 gets the eligible thread with the smallest branch count, miss count or in-flight instruction count respectively, with a count of FETCH_W. Ties go to the tied thread met first when scanning from the pointer.
- R10: A slot never carries a nonzero count for a thread that was not eligible. With no thread eligible, all counts are 0.
- R11: When mode_i = 7, all slots are 0.
- R12: Nonzero slots always name distinct threads, and their counts sum to at most FETCH_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Selection mode (0 to 7, see R3 to R11) |
| elig_i | input | NUM_THREADS | Per-thread fetch-eligible flags |
| long_lat_i | input | 1 | Primary thread has a long-latency instruction in the group |
| lead_run_i | input | $clog2(FETCH_W+1) | Primary-thread instructions ahead of the long-latency one |
| insn_cnt_i | input | NUM_THREADS x CNT_W | Per-thread in-flight instruction counts |
| br_cnt_i | input | NUM_THREADS x CNT_W | Per-thread in-flight branch counts |
| miss_cnt_i | input | NUM_THREADS x CNT_W | Per-thread outstanding miss counts |
| slot_tid_o | output | NUM_THREADS x $clog2(NUM_THREADS) | Thread ID per fetch slot |
| slot_cnt_o | output | NUM_THREADS x $clog2(FETCH_W+1) | Instruction count per fetch slot |

## Verification
The bench sweeps every eligibility mask in every mode, with counter patterns that tie, rise, fall and differ between the three counter kinds. A design that breaks ties by thread index instead of by the pointer would starve the higher threads, and the sweep catches this in the all-equal pattern. In split mode the lead-run sweep goes past the fetch width and includes zero, so a missing clamp or an off-by-one remainder shows up as a wrong slot 1 count or a total over budget. Pointer carry-over from one mode to the next is checked on every step, so a pointer that advances past the wrong slot or on idle cycles shifts every later rotation.

// File: rtl/smt_fetch_pkg.sv
package smt_fetch_pkg;
  typedef enum logic [2:0] {
    SEL_RR_WHOLE   = 3'd0,
    SEL_RR_HALF    = 3'd1,
    SEL_RR_QUARTER = 3'd2,
    SEL_SPLIT      = 3'd3,
    SEL_MIN_BR     = 3'd4,
    SEL_MIN_MISS   = 3'd5,
    SEL_MIN_INSN   = 3'd6,
    SEL_OFF        = 3'd7
  } sel_mode_e;
endpackage

// File: rtl/smt_rot_order.sv
// Compacts eligible threads in rotation order starting at ptr_i.
module smt_rot_order #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = $clog2(NUM_THREADS),
  localparam int NW    = $clog2(NUM_THREADS + 1)
) (
  input  logic [NUM_THREADS-1:0]            elig_i,
  input  logic [TID_W-1:0]                  ptr_i,
  output logic [NUM_THREADS-1:0][TID_W-1:0] order_o,
  output logic [NW-1:0]                     num_o
);
  always_comb begin
    logic [TID_W-1:0] t;
    logic [NW-1:0]    n;
    order_o = '0;
    n = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      t = ptr_i + TID_W'(k);
      if (elig_i[t]) begin
        order_o[TID_W'(n)] = t;
        n = n + NW'(1);
      end
    end
    num_o = n;
  end
endmodule

// File: rtl/smt_min_pick.sv
// Minimum search; first strict minimum in rotation order wins ties.
module smt_min_pick #(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 6,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0]            elig_i,
  input  logic [TID_W-1:0]                  ptr_i,
  input  logic [NUM_THREADS-1:0][CNT_W-1:0] key_i,
  output logic                              valid_o,
  output logic [TID_W-1:0]                  tid_o
);
  always_comb begin
    logic [TID_W-1:0] t;
    logic [CNT_W-1:0] best;
    valid_o = 1'b0;
    tid_o   = '0;
    best    = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      t = ptr_i + TID_W'(k);
      if (elig_i[t] && (!valid_o || key_i[t] < best)) begin
        valid_o = 1'b1;
        best    = key_i[t];
        tid_o   = t;
      end
    end
  end
endmodule

// File: rtl/smt_fetch_sel.sv
module smt_fetch_sel
  import smt_fetch_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int FETCH_W     = 8,
  parameter int CNT_W       = 6,
  localparam int TID_W = $clog2(NUM_THREADS),
  localparam int CW    = $clog2(FETCH_W + 1),
  localparam int NW    = $clog2(NUM_THREADS + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [2:0]                        mode_i,
  input  logic [NUM_THREADS-1:0]            elig_i,
  input  logic                              long_lat_i,
  input  logic [CW-1:0]                     lead_run_i,
  input  logic [NUM_THREADS-1:0][CNT_W-1:0] insn_cnt_i,
  input  logic [NUM_THREADS-1:0][CNT_W-1:0] br_cnt_i,
  input  logic [NUM_THREADS-1:0][CNT_W-1:0] miss_cnt_i,
  output logic [NUM_THREADS-1:0][TID_W-1:0] slot_tid_o,
  output logic [NUM_THREADS-1:0][CW-1:0]    slot_cnt_o
);
  localparam logic [CW-1:0] SHARE_WHOLE = CW'(FETCH_W);
  localparam logic [CW-1:0] SHARE_HALF  = CW'(FETCH_W / 2);
  localparam logic [CW-1:0] SHARE_QUART = CW'(FETCH_W / 4);

  sel_mode_e mode;
  assign mode = sel_mode_e'(mode_i);

  logic [TID_W-1:0] ptr_q, ptr_d;

  // rotation over all threads
  logic [NUM_THREADS-1:0][TID_W-1:0] ord_all;
  logic [NW-1:0]                     num_all;
  smt_rot_order #(.NUM_THREADS(NUM_THREADS)) u_ord_all (
    .elig_i (elig_i),
    .ptr_i  (ptr_q),
    .order_o(ord_all),
    .num_o  (num_all)
  );

  // rotation over secondary candidates (thread 0 excluded)
  logic [NUM_THREADS-1:0]            elig_sec;
  logic [NUM_THREADS-1:0][TID_W-1:0] ord_sec;
  logic [NW-1:0]                     num_sec;
  assign elig_sec = elig_i & ~NUM_THREADS'(1);
  smt_rot_order #(.NUM_THREADS(NUM_THREADS)) u_ord_sec (
    .elig_i (elig_sec),
    .ptr_i  (ptr_q),
    .order_o(ord_sec),
    .num_o  (num_sec)
  );

  // occupancy key for dynamic modes
  logic [NUM_THREADS-1:0][CNT_W-1:0] key;
  always_comb begin
    case (mode)
      SEL_MIN_BR:   key = br_cnt_i;
      SEL_MIN_MISS: key = miss_cnt_i;
      default:      key = insn_cnt_i;
    endcase
  end

  logic             min_vld;
  logic [TID_W-1:0] min_tid;
  smt_min_pick #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_min (
    .elig_i (elig_i),
    .ptr_i  (ptr_q),
    .key_i  (key),
    .valid_o(min_vld),
    .tid_o  (min_tid)
  );

  logic [CW-1:0] run;
  assign run = (lead_run_i > SHARE_WHOLE) ? SHARE_WHOLE : lead_run_i;

  logic [NUM_THREADS-1:0][TID_W-1:0] nxt_tid;
  logic [NUM_THREADS-1:0][CW-1:0]    nxt_cnt;

  always_comb begin
    nxt_tid = '0;
    nxt_cnt = '0;
    case (mode)
      SEL_RR_WHOLE: begin
        if (num_all != '0) begin
          nxt_tid[0] = ord_all[0];
          nxt_cnt[0] = SHARE_WHOLE;
        end
      end
      SEL_RR_HALF: begin
        for (int k = 0; k < 2; k++) begin
          if (k < int'(num_all)) begin
            nxt_tid[k] = ord_all[k];
            nxt_cnt[k] = SHARE_HALF;
          end
        end
      end
      SEL_RR_QUARTER: begin
        for (int k = 0; k < 4; k++) begin
          if (k < int'(num_all)) begin
            nxt_tid[k] = ord_all[k];
            nxt_cnt[k] = SHARE_QUART;
          end
        end
      end
      SEL_SPLIT: begin
        if (!elig_i[0]) begin
          if (num_sec != '0) begin
            nxt_tid[1] = ord_sec[0];
            nxt_cnt[1] = SHARE_WHOLE;
          end
        end else if (!long_lat_i) begin
          nxt_cnt[0] = SHARE_WHOLE;
        end else begin
          nxt_cnt[0] = run;
          if (num_sec != '0 && run < SHARE_WHOLE) begin
            nxt_tid[1] = ord_sec[0];
            nxt_cnt[1] = SHARE_WHOLE - run;
          end
        end
      end
      SEL_MIN_BR, SEL_MIN_MISS, SEL_MIN_INSN: begin
        if (min_vld) begin
          nxt_tid[0] = min_tid;
          nxt_cnt[0] = SHARE_WHOLE;
        end
      end
      default: ;
    endcase
  end

  // pointer moves past the last slot that got fetch bandwidth
  always_comb begin
    ptr_d = ptr_q;
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (nxt_cnt[k] != '0) ptr_d = nxt_tid[k] + TID_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      slot_tid_o <= '0;
      slot_cnt_o <= '0;
    end else begin
      ptr_q      <= ptr_d;
      slot_tid_o <= nxt_tid;
      slot_cnt_o <= nxt_cnt;
    end
  end
endmodule

// File: rtl/smt_fetch_sel_chk.sv
module smt_fetch_sel_chk #(
  parameter int NUM_THREADS = 4,
  parameter int FETCH_W     = 8,
  localparam int TID_W = $clog2(NUM_THREADS),
  localparam int CW    = $clog2(FETCH_W + 1)
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [2:0]                        mode_i,
  input logic [NUM_THREADS-1:0]            elig_i,
  input logic [NUM_THREADS-1:0][TID_W-1:0] slot_tid_o,
  input logic [NUM_THREADS-1:0][CW-1:0]    slot_cnt_o
);
  logic [NUM_THREADS-1:0] elig_q;
  int unsigned total;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) elig_q <= '0;
    else         elig_q <= elig_i;
  end

  always_comb begin
    total = 0;
    for (int k = 0; k < NUM_THREADS; k++) total += int'(slot_cnt_o[k]);
  end

  // R12
  width_budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    total <= FETCH_W);

  // R10
  none_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_i == '0) |=> (total == 0));

  // R11
  mode_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd7) |=> (total == 0));

  // R3
  whole_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0 && elig_i != '0) |=> (int'(slot_cnt_o[0]) == FETCH_W));

  for (genvar s = 0; s < NUM_THREADS; s++) begin : g_slot
    // R10
    eligible_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_cnt_o[s] != '0) |-> elig_q[slot_tid_o[s]]);
    for (genvar r = s + 1; r < NUM_THREADS; r++) begin : g_pair
      // R12
      distinct_tid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_cnt_o[s] != '0 && slot_cnt_o[r] != '0) |-> (slot_tid_o[s] != slot_tid_o[r]));
    end
  end
endmodule

bind smt_fetch_sel smt_fetch_sel_chk #(
  .NUM_THREADS(NUM_THREADS),
  .FETCH_W    (FETCH_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .elig_i    (elig_i),
  .slot_tid_o(slot_tid_o),
  .slot_cnt_o(slot_cnt_o)
);

// File: tb/smt_fetch_sel_test.sv
module smt_fetch_sel_test;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int CW = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [2:0]      mode_i = '0;
  logic [N-1:0]    elig_i = '0;
  logic            long_lat_i = 1'b0;
  logic [CW-1:0]   lead_run_i = '0;
  logic [N-1:0][5:0] insn_cnt_i = '0, br_cnt_i = '0, miss_cnt_i = '0;
  logic [N-1:0][1:0] slot_tid_o;
  logic [N-1:0][CW-1:0] slot_cnt_o;

  smt_fetch_sel uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .elig_i(elig_i),
    .long_lat_i(long_lat_i), .lead_run_i(lead_run_i),
    .insn_cnt_i(insn_cnt_i), .br_cnt_i(br_cnt_i), .miss_cnt_i(miss_cnt_i),
    .slot_tid_o(slot_tid_o), .slot_cnt_o(slot_cnt_o)
  );

  always #10 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  int mptr = 0;
  int exp_tid[N];
  int exp_cnt[N];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pat(int p, int t);
    case (p)
      0: return 7;
      1: return 40 - 10 * t;
      2: return (t * 7) % 3;
      default: return 63 - t * 21;
    endcase
  endfunction

  // expected selection per requirements R3..R11, plus pointer rule R6
  task automatic model();
    int ord[N];
    int n = 0;
    int key[N];
    int m = int'(mode_i);
    for (int k = 0; k < N; k++) begin exp_tid[k] = 0; exp_cnt[k] = 0; end
    for (int k = 0; k < N; k++) begin
      int t = (mptr + k) % N;
      if (elig_i[t]) begin ord[n] = t; n++; end
    end
    for (int t = 0; t < N; t++)
      key[t] = (m == 4) ? int'(br_cnt_i[t]) : (m == 5) ? int'(miss_cnt_i[t]) : int'(insn_cnt_i[t]);
    if (m == 0 && n > 0) begin exp_tid[0] = ord[0]; exp_cnt[0] = W; end
    if (m == 1) for (int k = 0; k < 2; k++) if (k < n) begin exp_tid[k] = ord[k]; exp_cnt[k] = W / 2; end
    if (m == 2) for (int k = 0; k < 4; k++) if (k < n) begin exp_tid[k] = ord[k]; exp_cnt[k] = W / 4; end
    if (m == 3) begin
      int sec = -1;
      int r = (int'(lead_run_i) > W) ? W : int'(lead_run_i);
      for (int k = 0; k < N; k++) begin
        int t = (mptr + k) % N;
        if (sec < 0 && t != 0 && elig_i[t]) sec = t;
      end
      if (!elig_i[0]) begin
        if (sec >= 0) begin exp_tid[1] = sec; exp_cnt[1] = W; end
      end else if (!long_lat_i) begin
        exp_cnt[0] = W;
      end else begin
        exp_cnt[0] = r;
        if (sec >= 0 && r < W) begin exp_tid[1] = sec; exp_cnt[1] = W - r; end
      end
    end
    if (m >= 4 && m <= 6) begin
      int best = -1;
      for (int k = 0; k < N; k++) begin
        int t = (mptr + k) % N;
        if (elig_i[t] && (best < 0 || key[t] < key[best])) best = t;
      end
      if (best >= 0) begin exp_tid[0] = best; exp_cnt[0] = W; end
    end
    for (int k = 0; k < N; k++) if (exp_cnt[k] != 0) mptr = (exp_tid[k] + 1) % N;
  endtask

  task automatic compare(string req);
    int tot = 0;
    for (int k = 0; k < N; k++) begin
      chk(req, $sformatf("slot%0d tid", k), int'(slot_tid_o[k]), exp_tid[k]);
      chk(req, $sformatf("slot%0d cnt", k), int'(slot_cnt_o[k]), exp_cnt[k]);
      tot += int'(slot_cnt_o[k]);
    end
    chk("R12", "total within width", (tot <= W) ? 1 : 0, 1);
  endtask

  function automatic string tag_of();
    if (elig_i == '0) return "R10";
    case (int'(mode_i))
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return long_lat_i ? "R8" : "R7";
      7: return "R11";
      default: return "R9";
    endcase
  endfunction

  // called at a negedge with inputs already driven
  task automatic step();
    string tg = tag_of();
    model();
    @(negedge clk_i);
    compare(tg);
  endtask

  task automatic set_pattern(int p);
    for (int t = 0; t < N; t++) begin
      insn_cnt_i[t] = 6'(pat(p, t));
      br_cnt_i[t]   = 6'(pat(p, (t + 1) % N));
      miss_cnt_i[t] = 6'(pat(p, (t + 2) % N));
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mode_i = 3'd0; elig_i = '1;
    repeat (3) @(negedge clk_i);
    // R1: reset holds every slot at zero
    for (int k = 0; k < N; k++) begin
      chk("R1", "reset tid", int'(slot_tid_o[k]), 0);
      chk("R1", "reset cnt", int'(slot_cnt_o[k]), 0);
    end
    rst_ni = 1'b1;
    mptr = 0;

    // R6: rotation of the whole width over all threads, pointer starts at 0
    for (int i = 0; i < 6; i++) begin
      string tg = "R6";
      model();
      @(negedge clk_i);
      compare(tg);
      chk("R6", "rotation order", int'(slot_tid_o[0]), i % N);
    end

    // R2: output held between edges, then follows the sampled inputs
    mode_i = 3'd1; elig_i = 4'b0110;
    model();
    @(negedge clk_i);
    compare("R2");
    mode_i = 3'd7; elig_i = 4'b1001;
    #5;
    compare("R2");
    step();

    // sweep of every mode, mask and pattern
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 4; p++) begin
        set_pattern(p);
        for (int e = 0; e < 16; e++) begin
          mode_i = 3'(m);
          elig_i = 4'(e);
          if (m == 3) begin
            for (int ll = 0; ll < 2; ll++) begin
              for (int r = 0; r < 10; r++) begin
                long_lat_i = ll[0];
                lead_run_i = 4'(r);
                step();
              end
            end
          end else begin
            long_lat_i = 1'b0;
            lead_run_i = '0;
            step();
          end
        end
      end
    end

    // R9: ties in dynamic modes rotate rather than repeat
    set_pattern(0);
    mode_i = 3'd6; elig_i = '1;
    for (int i = 0; i < 5; i++) step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule